// File: doc/BRIEF.md
# Shifted-Operand Data-Processing Execute Unit

This block is the execute stage for register-only data-processing operations. Each cycle it takes a decoded operation: a four-bit opcode, a condition field, a flag-update bit, a first operand and the ingredients of a second operand. The second operand is always prepared in one of two ways. Either a register value goes through a barrel shifter, with the amount taken from a five-bit immediate or from the low byte of a third register. Or an eight-bit constant is rotated right by twice a four-bit rotate field.

The result and the destination write-enable are combinational in the same cycle. The N, Z, C and V flags are held in a register inside the block and are updated on the clock edge that ends the operation. The current flags decide whether the condition passes, supply the carry-in for the carry-using arithmetic, and supply the carry for shifts that leave it unchanged. A decoder upstream drives the operands from the register file. The write-back logic downstream consumes `result` when `rd_we` is high.

Top module: `exu_shifted_alu`

## Requirements
- R1: Opcode values 2,3,4,5,6,7 select SUB (rn-op2), RSB (op2-rn), ADD, ADC (rn+op2+C), SBC (rn-op2-1+C) and RSC (op2-rn-1+C). C is the registered carry flag.
- R2: Opcode values 0,1,12,14 select AND, EOR, ORR and BIC (rn AND NOT op2) of the first operand with the second.
- R3: Opcodes 13 (MOV) and 15 (MVN) return op2 and its complement, whatever the first operand holds.
- R4: With `use_imm` high, op2 is `imm_val` zero-extended and rotated right by 2*`imm_rot`. The shifter carry is bit 31 of that value when `imm_rot` is nonzero, and the old C otherwise.
- R5: On a flag update, N is result bit 31 and Z is set when the result is zero. For arithmetic, C is the carry out of the adder (NOT borrow for subtracts) and V is signed overflow. `flags` is {N,Z,C,V}, with N in bit 3.
- R6: On a flag update by a logical, move or test opcode, C takes the shifter carry and V keeps its old value.
- R7: Opcodes 8..11 (TST, TEQ, CMP, CMN) compute AND, EOR, SUB and ADD. They update the flags even with `set_flags` low and never raise `rd_we`.
- R8: Condition codes 0..14 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE and AL, tested against the registered flags. Code 15 never passes. A failing condition keeps `rd_we` low and leaves the flags unchanged.
- R9: With `set_flags` low, a passing non-test operation leaves the flags unchanged. With `op_valid` low, `rd_we` stays low and the flags hold.
- R10: For an immediate amount, `shift_kind` 0..3 is LSL, LSR, ASR, ROR. A zero amount means no shift for LSL, a shift by 32 for LSR and ASR, and rotate-through-carry by one (C into bit 31, bit 0 out as carry) for ROR.
- R11: For a register amount, only the low byte of `rs_val` counts. Zero leaves the value and C unchanged. LSL and LSR by 32 give zero with carry bit 0 or bit 31 respectively, and by more than 32 give zero with carry 0. ASR by 32 or more gives sign fill with carry bit 31. ROR rotates by the amount modulo 32.
- R12: An active-low `rst_n` clears the flags to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| cond | input | 4 | Condition field |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update |
| rn_val | input | 32 | First operand |
| use_imm | input | 1 | Second operand from rotated immediate |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field (rotate by twice this) |
| rm_val | input | 32 | Register to be shifted |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_by_reg | input | 1 | Shift amount from `rs_val` low byte |
| shift_imm | input | 5 | Immediate shift amount |
| rs_val | input | 32 | Register holding the shift amount |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination write-enable |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
A corrupted flag register shows at the ports on the very next operation. A condition that should pass is gated off, or the reverse, so `rd_we` flips in that same cycle. A carry-using operation returns a result off by one. Because each check first loads a known flag state with a compare, a flag bit latched on the wrong edge or not at all differs from its expected value one clock after the operation that should have set it.

// File: rtl/exu_pkg.sv
package exu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
   } shift_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   function automatic logic op_is_test(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

endpackage

// File: rtl/exu_imm_expand.sv
module exu_imm_expand #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   input  logic              c_in,
   output logic [DATA_W-1:0] value,
   output logic              c_out
);
   localparam int NROT = 1 << ROT_W;

   logic [DATA_W-1:0] base;
   logic [DATA_W-1:0] cand [NROT];

   assign base = {{(DATA_W-IMM_W){1'b0}}, imm};

   for (genvar k = 0; k < NROT; k++) begin : g_rot
      logic [2*DATA_W-1:0] dbl;
      assign dbl     = {base, base} >> (2 * k);
      assign cand[k] = dbl[DATA_W-1:0];
   end

   assign value = cand[rot];
   assign c_out = (rot == '0) ? c_in : value[DATA_W-1];

endmodule

// File: rtl/exu_barrel.sv
module exu_barrel
   import exu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] val,
   input  shift_e            kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              rrx,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);
   localparam int SHW = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

   logic [DATA_W:0]        lsl_x;
   logic [DATA_W:0]        lsr_x;
   logic signed [DATA_W:0] asr_x;
   logic [AMT_W-1:0]       asr_amt;
   logic [2*DATA_W-1:0]    ror_x;
   logic [SHW-1:0]         ror_amt;

   always_comb begin
      asr_amt = (amt > FULL) ? FULL : amt;
      ror_amt = amt[SHW-1:0];
      lsl_x   = {1'b0, val} << amt;
      lsr_x   = {val, 1'b0} >> amt;
      asr_x   = $signed({val, 1'b0}) >>> asr_amt;
      ror_x   = {val, val} >> ror_amt;
   end

   always_comb begin
      res   = val;
      c_out = c_in;
      if (rrx) begin
         res   = {c_in, val[DATA_W-1:1]};
         c_out = val[0];
      end else if (amt != '0) begin
         unique case (kind)
            SH_LSL: begin
               if (amt > FULL) begin
                  res   = '0;
                  c_out = 1'b0;
               end else begin
                  res   = lsl_x[DATA_W-1:0];
                  c_out = lsl_x[DATA_W];
               end
            end
            SH_LSR: begin
               if (amt > FULL) begin
                  res   = '0;
                  c_out = 1'b0;
               end else begin
                  res   = lsr_x[DATA_W:1];
                  c_out = lsr_x[0];
               end
            end
            SH_ASR: begin
               res   = asr_x[DATA_W:1];
               c_out = asr_x[0];
            end
            default: begin
               res   = ror_x[DATA_W-1:0];
               c_out = ror_x[DATA_W-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c_in,
   input  logic              v_in,
   input  logic              sh_c,
   output logic [DATA_W-1:0] res,
   output flags_t            fl
);
   logic [DATA_W-1:0] x, y;
   logic              ci;
   logic              arith;
   logic [DATA_W:0]   sum;

   always_comb begin
      x     = a;
      y     = b;
      ci    = 1'b0;
      arith = 1'b1;
      unique case (op)
         OP_ADD, OP_CMN: ci = 1'b0;
         OP_ADC:         ci = c_in;
         OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
         OP_SBC:         begin y = ~b; ci = c_in; end
         OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
         OP_RSC:         begin x = b; y = ~a; ci = c_in; end
         default:        arith = 1'b0;
      endcase
   end

   assign sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_MOV:         res = b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = sum[DATA_W-1:0];
      endcase
   end

   always_comb begin
      fl.n = res[DATA_W-1];
      fl.z = (res == '0);
      fl.c = arith ? sum[DATA_W] : sh_c;
      fl.v = arith ? ((x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]))
                   : v_in;
   end

endmodule

// File: rtl/exu_cond.sv
module exu_cond
   import exu_pkg::*;
(
   input  logic [3:0] cond,
   input  flags_t     fl,
   output logic       pass
);
   logic base;

   always_comb begin
      unique case (cond[3:1])
         3'd0:    base = fl.z;
         3'd1:    base = fl.c;
         3'd2:    base = fl.n;
         3'd3:    base = fl.v;
         3'd4:    base = fl.c & ~fl.z;
         3'd5:    base = (fl.n == fl.v);
         3'd6:    base = ~fl.z & (fl.n == fl.v);
         default: base = 1'b1;
      endcase
   end

   assign pass = (cond == 4'hF) ? 1'b0 : (cond[0] ? ~base : base);

endmodule

// File: rtl/exu_shifted_alu.sv
module exu_shifted_alu
   import exu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter int AMT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        cond,
   input  logic [3:0]        opcode,
   input  logic              set_flags,
   input  logic [DATA_W-1:0] rn_val,
   input  logic              use_imm,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   input  logic [DATA_W-1:0] rm_val,
   input  logic [1:0]        shift_kind,
   input  logic              shift_by_reg,
   input  logic [$clog2(DATA_W)-1:0] shift_imm,
   input  logic [DATA_W-1:0] rs_val,
   output logic [DATA_W-1:0] result,
   output logic              rd_we,
   output logic [3:0]        flags
);
   localparam int SHW = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

   if (DATA_W != 2 * (1 << ROT_W)) begin : g_bad_rot
      $error("rotate field must span the full data width");
   end
   if (IMM_W > DATA_W || IMM_W < 1) begin : g_bad_imm
      $error("immediate width out of range");
   end
   if (AMT_W < SHW + 1 || DATA_W >= (1 << AMT_W)) begin : g_bad_amt
      $error("shift amount field too narrow");
   end
   if ((1 << SHW) != DATA_W) begin : g_bad_w
      $error("data width must be a power of two");
   end

   flags_t flags_q, flags_d, alu_fl;
   shift_e kind;
   logic [DATA_W-1:0] imm_op2, sh_op2, op2, alu_res;
   logic              imm_c, sh_c, op2_c, pass, is_test, upd;
   logic [AMT_W-1:0]  amt;
   logic              rrx;

   assign kind    = shift_e'(shift_kind);
   assign is_test = op_is_test(opcode);

   always_comb begin
      rrx = 1'b0;
      if (shift_by_reg) begin
         amt = rs_val[AMT_W-1:0];
      end else if (shift_imm == '0 && (kind == SH_LSR || kind == SH_ASR)) begin
         amt = FULL_AMT;
      end else begin
         amt = AMT_W'(shift_imm);
         rrx = (kind == SH_ROR) && (shift_imm == '0);
      end
   end

   exu_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
      .imm(imm_val), .rot(imm_rot), .c_in(flags_q.c), .value(imm_op2), .c_out(imm_c)
   );

   exu_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .val(rm_val), .kind(kind), .amt(amt), .rrx(rrx), .c_in(flags_q.c),
      .res(sh_op2), .c_out(sh_c)
   );

   assign op2   = use_imm ? imm_op2 : sh_op2;
   assign op2_c = use_imm ? imm_c   : sh_c;

   exu_alu #(.DATA_W(DATA_W)) u_alu (
      .op(alu_op_e'(opcode)), .a(rn_val), .b(op2), .c_in(flags_q.c),
      .v_in(flags_q.v), .sh_c(op2_c), .res(alu_res), .fl(alu_fl)
   );

   exu_cond u_cond (.cond(cond), .fl(flags_q), .pass(pass));

   assign result = alu_res;
   assign rd_we  = op_valid && pass && !is_test;
   assign upd    = op_valid && pass && (set_flags || is_test);
   assign flags_d = upd ? alu_fl : flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags = flags_q;

   a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode[3:2] == 2'b10) |-> !rd_we);

   a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && (set_flags || opcode[3:2] == 2'b10)) |=> $stable(flags));

   a_r8_always_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond == 4'hE && opcode[3:2] != 2'b10) |-> rd_we);

   a_r8_never_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond == 4'hF) |-> !rd_we);

   a_r8_never_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && cond == 4'hF) |=> $stable(flags));

   a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we && set_flags) |=> (flags[2] == ($past(result) == '0)));

   a_r5_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we && set_flags) |=> (flags[3] == $past(result[DATA_W-1])));

   a_r6_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_we && set_flags && (opcode inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15}))
      |=> (flags[0] == $past(flags[0])));

endmodule

// File: tb/sim_exu_shifted_alu.sv
module sim_exu_shifted_alu;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [7:0]  req;
      logic [3:0]  pre;
      logic [3:0]  cnd;
      logic [3:0]  opc;
      logic        s;
      logic [31:0] rn;
      logic        ui;
      logic [7:0]  imm;
      logic [3:0]  rot;
      logic [31:0] rm;
      logic [1:0]  sht;
      logic        br;
      logic [4:0]  shi;
      logic [31:0] rs;
      logic [31:0] res;
      logic        we;
      logic [3:0]  fl;
   } vec_t;

   function automatic vec_t mk(
      input logic [7:0] req, input logic [3:0] pre, input logic [3:0] cnd,
      input logic [3:0] opc, input logic s, input logic [31:0] rn,
      input logic ui, input logic [7:0] imm, input logic [3:0] rot,
      input logic [31:0] rm, input logic [1:0] sht, input logic br,
      input logic [4:0] shi, input logic [31:0] rs, input logic [31:0] res,
      input logic we, input logic [3:0] fl);
      vec_t v;
      v = '{req, pre, cnd, opc, s, rn, ui, imm, rot, rm, sht, br, shi, rs, res, we, fl};
      return v;
   endfunction

   localparam int NV = 38;
   localparam vec_t VECS [NV] = '{
      // R1 R10 arithmetic with immediate-amount LSL
      mk(1, 4'h0, 4'hE, 4'd4,  1, 32'd5,         0, 8'd0,  4'd0, 32'd3,         2'd0, 0, 5'd2, 0, 32'h11,       1, 4'b0000),
      mk(5, 4'h0, 4'hE, 4'd4,  1, 32'hFFFFFFFF,  1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'h0,        1, 4'b0110),
      mk(1, 4'h2, 4'hE, 4'd5,  1, 32'd10,        1, 8'd5,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'h10,       1, 4'b0000),
      mk(5, 4'h0, 4'hE, 4'd2,  1, 32'd3,         1, 8'd5,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'hFFFFFFFE, 1, 4'b1000),
      mk(1, 4'h0, 4'hE, 4'd6,  1, 32'd10,        1, 8'd3,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd6,        1, 4'b0010),
      mk(1, 4'h0, 4'hE, 4'd3,  1, 32'd1,         0, 8'd0,  4'd0, 32'h10,        2'd1, 0, 5'd4, 0, 32'h0,        1, 4'b0110),
      mk(1, 4'h2, 4'hE, 4'd7,  1, 32'd2,         1, 8'd7,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd5,        1, 4'b0010),
      // R2 R6 logical operations
      mk(2, 4'h0, 4'hE, 4'd0,  1, 32'hFF00FF00,  0, 8'd0,  4'd0, 32'h0F0F0F0F,  2'd0, 0, 5'd0, 0, 32'h0F000F00,  1, 4'b0000),
      mk(4, 4'h9, 4'hE, 4'd12, 1, 32'h1,         1, 8'h01, 4'd1, 0,             2'd0, 0, 5'd0, 0, 32'h40000001, 1, 4'b0001),
      mk(2, 4'h0, 4'hE, 4'd1,  1, 32'h12345678,  0, 8'd0,  4'd0, 32'h12345678,  2'd0, 0, 5'd0, 0, 32'h0,        1, 4'b0100),
      mk(4, 4'h0, 4'hE, 4'd14, 1, 32'hFFFFFFFF,  1, 8'hFF, 4'd4, 0,             2'd0, 0, 5'd0, 0, 32'h00FFFFFF, 1, 4'b0010),
      // R3 moves ignore rn
      mk(3, 4'h0, 4'hE, 4'd13, 1, 32'hDEADBEEF,  0, 8'd0,  4'd0, 32'h80000001,  2'd2, 0, 5'd1, 0, 32'hC0000000, 1, 4'b1010),
      mk(3, 4'h2, 4'hE, 4'd15, 1, 32'hDEADBEEF,  1, 8'd0,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'hFFFFFFFF, 1, 4'b1010),
      // R7 compare and test
      mk(7, 4'h0, 4'hE, 4'd10, 0, 32'd5,         1, 8'd5,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'h0,        0, 4'b0110),
      mk(7, 4'h2, 4'hE, 4'd8,  0, 32'hF0,        1, 8'h0F, 4'd0, 0,             2'd0, 0, 5'd0, 0, 32'h0,        0, 4'b0110),
      mk(7, 4'h0, 4'hE, 4'd9,  0, 32'h80000000,  0, 8'd0,  4'd0, 32'h0,         2'd0, 0, 5'd0, 0, 32'h80000000, 0, 4'b1000),
      mk(7, 4'h0, 4'hE, 4'd11, 0, 32'h7FFFFFFF,  1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'h80000000, 0, 4'b1001),
      // R11 register-amount shifts
      mk(11, 4'h0, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h1,         2'd0, 1, 5'd0, 32'd32,       32'h0,        1, 4'b0110),
      mk(11, 4'h0, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h80000000,  2'd1, 1, 5'd0, 32'hFFFFFF28, 32'h0,        1, 4'b0100),
      mk(11, 4'h0, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h80000000,  2'd2, 1, 5'd0, 32'd200,      32'hFFFFFFFF, 1, 4'b1010),
      mk(11, 4'h6, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'hF1,        2'd3, 1, 5'd0, 32'd4,        32'h1000000F, 1, 4'b0000),
      mk(11, 4'h2, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h12345678,  2'd1, 1, 5'd0, 32'h100,      32'h12345678, 1, 4'b0010),
      // R10 zero immediate amounts
      mk(10, 4'h2, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h3,         2'd3, 0, 5'd0, 0, 32'h80000001, 1, 4'b1010),
      mk(10, 4'h0, 4'hE, 4'd13, 1, 0,            0, 8'd0,  4'd0, 32'h80000000,  2'd1, 0, 5'd0, 0, 32'h0,        1, 4'b0110),
      // R8 R9 condition gating
      mk(8, 4'h0, 4'h0, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0000),
      mk(8, 4'h0, 4'h1, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        1, 4'b0000),
      mk(8, 4'h0, 4'hC, 4'd2,  1, 32'd9,         1, 8'd4,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd5,        1, 4'b0010),
      mk(8, 4'h0, 4'hB, 4'd2,  1, 32'd9,         1, 8'd4,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd5,        0, 4'b0000),
      mk(9, 4'h2, 4'h8, 4'd4,  0, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        1, 4'b0010),
      mk(8, 4'h2, 4'h9, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0010),
      mk(8, 4'h9, 4'hA, 4'd4,  1, 32'd0,         1, 8'd0,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd0,        1, 4'b0100),
      mk(8, 4'h8, 4'h4, 4'd4,  0, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        1, 4'b1000),
      mk(8, 4'h0, 4'h6, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0000),
      mk(8, 4'h0, 4'hF, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0000),
      mk(8, 4'h6, 4'hD, 4'd4,  0, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        1, 4'b0110),
      mk(8, 4'h2, 4'h3, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0010),
      mk(8, 4'h8, 4'h5, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b1000),
      mk(8, 4'h3, 4'h7, 4'd4,  1, 32'd1,         1, 8'd1,  4'd0, 0,             2'd0, 0, 5'd0, 0, 32'd2,        0, 4'b0011)
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  cond = 4'hE;
   logic [3:0]  opcode = 4'd0;
   logic        set_flags = 1'b0;
   logic [31:0] rn_val = '0;
   logic        use_imm = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [3:0]  imm_rot = '0;
   logic [31:0] rm_val = '0;
   logic [1:0]  shift_kind = '0;
   logic        shift_by_reg = 1'b0;
   logic [4:0]  shift_imm = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] result;
   logic        rd_we;
   logic [3:0]  flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exu_shifted_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond(cond), .opcode(opcode),
      .set_flags(set_flags), .rn_val(rn_val), .use_imm(use_imm), .imm_val(imm_val),
      .imm_rot(imm_rot), .rm_val(rm_val), .shift_kind(shift_kind),
      .shift_by_reg(shift_by_reg), .shift_imm(shift_imm), .rs_val(rs_val),
      .result(result), .rd_we(rd_we), .flags(flags)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Issue a compare that leaves the flags in a known state
   task automatic prime(input logic [3:0] target);
      @(negedge clk);
      op_valid = 1'b1; cond = 4'hE; set_flags = 1'b0; use_imm = 1'b0;
      shift_kind = 2'd0; shift_by_reg = 1'b0; shift_imm = 5'd0;
      case (target)
         4'b0010: begin opcode = 4'd10; rn_val = 32'd2;         rm_val = 32'd1; end
         4'b0110: begin opcode = 4'd10; rn_val = 32'd5;         rm_val = 32'd5; end
         4'b1000: begin opcode = 4'd10; rn_val = 32'd1;         rm_val = 32'd2; end
         4'b1001: begin opcode = 4'd11; rn_val = 32'h7FFFFFFF;  rm_val = 32'd1; end
         4'b0011: begin opcode = 4'd10; rn_val = 32'h80000000;  rm_val = 32'd1; end
         default: begin opcode = 4'd11; rn_val = 32'd1;         rm_val = 32'd1; end
      endcase
      @(posedge clk);
      #1 op_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 flags in reset", {28'd0, flags}, 32'd0);
      check("R12 no write in reset", {31'd0, rd_we}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         prime(VECS[i].pre);
         check($sformatf("R12 prime %0d", i), {28'd0, flags}, {28'd0, VECS[i].pre});
         @(negedge clk);
         op_valid = 1'b1; cond = VECS[i].cnd; opcode = VECS[i].opc;
         set_flags = VECS[i].s; rn_val = VECS[i].rn; use_imm = VECS[i].ui;
         imm_val = VECS[i].imm; imm_rot = VECS[i].rot; rm_val = VECS[i].rm;
         shift_kind = VECS[i].sht; shift_by_reg = VECS[i].br;
         shift_imm = VECS[i].shi; rs_val = VECS[i].rs;
         #1;
         check($sformatf("R%0d result v%0d", VECS[i].req, i), result, VECS[i].res);
         check($sformatf("R%0d rd_we v%0d", VECS[i].req, i), {31'd0, rd_we}, {31'd0, VECS[i].we});
         @(posedge clk);
         #1;
         op_valid = 1'b0;
         check($sformatf("R%0d flags v%0d", VECS[i].req, i), {28'd0, flags}, {28'd0, VECS[i].fl});
      end

      // R9 op_valid low: no write, flags hold
      prime(4'b1001);
      @(negedge clk);
      op_valid = 1'b0; cond = 4'hE; opcode = 4'd4; set_flags = 1'b1;
      rn_val = 32'd0; use_imm = 1'b1; imm_val = 8'd0; imm_rot = 4'd0;
      #1 check("R9 idle no write", {31'd0, rd_we}, 32'd0);
      @(posedge clk); #1;
      check("R9 idle flags hold", {28'd0, flags}, 32'b1001);

      // R3 MOV with different rn gives the same result
      @(negedge clk);
      op_valid = 1'b1; opcode = 4'd13; set_flags = 1'b0; use_imm = 1'b1;
      imm_val = 8'hA5; imm_rot = 4'd0; rn_val = 32'h0;
      #1 check("R3 mov rn zero", result, 32'hA5);
      rn_val = 32'hFFFFFFFF;
      #1 check("R3 mov rn ones", result, 32'hA5);
      @(posedge clk); #1 op_valid = 1'b0;

      // R4 rotate by 30 wraps low bits into the top
      @(negedge clk);
      op_valid = 1'b1; opcode = 4'd13; use_imm = 1'b1; imm_val = 8'hC3; imm_rot = 4'd15;
      #1 check("R4 imm rotate 30", result, 32'h0000030C);
      @(posedge clk); #1 op_valid = 1'b0;

      // R12 reset mid-run clears flags
      prime(4'b1000);
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R12 async clear", {28'd0, flags}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule